// File: doc/BRIEF.md
# OVSF Channelisation Code Generator

This block produces the real-valued orthogonal variable spreading factor code used to spread the I and Q branches of a downlink channel. The spreading factor is given as its base-two logarithm (2 to 8, so SF runs from 4 to 256), together with a code index k. Every chip is computed directly: it is the parity of the bitwise AND of a chip counter with the code index bit-reversed over n bits. No code tree is stored.

In serial mode the block emits one chip per enabled cycle. The first chip in time comes first. A symbol-start strobe aligns the sequence, and the code restarts by itself every SF chips. In word mode it emits a whole 32-chip word in one cycle for SF up to 32. When SF is below 32, the word holds 32/SF back-to-back copies of the code. The same chip value serves both the I branch and the Q branch. An index that does not fit the spreading factor is reported, and the output is then forced to +1.

Top module: `ovsf_code_gen`

## Requirements
- R1: After reset, `chip_vld`, `word_vld`, `sym_bound` and `code_err` are 0.
- R2: In serial mode the chips are encoded as 0 for +1 and 1 for -1. The chip sequence equals C(SF,k), built as C(1,0)=[+1], C(2SF,2k)=[C(SF,k),C(SF,k)] and C(2SF,2k+1)=[C(SF,k),-C(SF,k)]. Chip 0 appears with `chip_vld` in the cycle after the edge that samples `en` and `sym_start` high.
- R3: Without a new strobe, the code repeats every SF enabled cycles. `sym_bound` is high exactly on chip 0 of each repetition.
- R4: A `sym_start` taken in the middle of a symbol restarts at chip 0, using the newly sampled `sf_log2` and `code_idx`.
- R5: While `en` is low, `chip_vld` falls and the chip position holds, and `sym_start` is ignored. Once `en` returns, the chip that follows the last one shown comes out.
- R6: With `par_mode` high and `en` high, `word_out` bit j equals chip (j mod SF) of C(SF,k) one cycle later, with `word_vld` and `sym_bound` high.
- R7: If `code_idx` is at least SF, or `sf_log2` lies outside 2..8, `code_err` is high and every output chip is 0 (+1) while valid.
- R8: In word mode, a `sf_log2` above 5 raises `code_err` and gives a zero word.
- R9: `chip_vld` and `word_vld` are never high together. A word-mode cycle stops the serial sequence until the next `sym_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Advance / generate enable |
| sym_start | input | 1 | Serial symbol-start strobe |
| par_mode | input | 1 | 1 selects word mode, 0 selects serial mode |
| sf_log2 | input | 4 | log2 of the spreading factor |
| code_idx | input | 8 | Code index k |
| chip_out | output | 1 | Serial chip, 0 means +1 and 1 means -1 |
| chip_vld | output | 1 | Serial chip valid |
| word_out | output | 32 | Word-mode chips, bit j is chip j |
| word_vld | output | 1 | Word valid |
| sym_bound | output | 1 | Output starts a symbol |
| code_err | output | 1 | Index or spreading factor not usable |

## Verification
Two serial functions can fall in the same cycle: the automatic wrap after chip SF-1 and a fresh `sym_start`. The sweep starts every new code on the edge where the previous code would wrap, so the two always coincide there. The bench then checks that chip 0 of the new code, not of the old one, appears with the boundary flag. A second coincidence is a strobe that arrives while `en` is low. The bench drives it there and judges that the chip position is unchanged after `en` returns.

// File: rtl/ovsf_pkg.sv
package ovsf_pkg;
    localparam int OVSF_MAX_LOG = 8;
    localparam int OVSF_MIN_LOG = 2;
    localparam int OVSF_WORD_W  = 32;

    typedef enum logic {
        MODE_SERIAL = 1'b0,
        MODE_WORD   = 1'b1
    } ovsf_mode_e;
endpackage

// File: rtl/ovsf_bitrev.sv
module ovsf_bitrev #(
    parameter int W  = 8,
    parameter int LW = 4
) (
    input  logic [W-1:0]  idx,
    input  logic [LW-1:0] n,
    output logic [W-1:0]  rev
);
    logic [W-1:0] rev_full;
    logic [LW:0]  shamt;

    for (genvar i = 0; i < W; i++) begin : g_rev
        assign rev_full[i] = idx[W-1-i];
    end

    // Bit b of idx lands on W-1-b; shifting right by W-n puts it on n-1-b.
    assign shamt = (LW+1)'(W) - {1'b0, n};
    assign rev   = rev_full >> shamt;
endmodule

// File: rtl/ovsf_chip_lane.sv
module ovsf_chip_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] rev,
    output logic         chip
);
    assign chip = ^(cnt & rev);
endmodule

// File: rtl/ovsf_seq_ctrl.sv
module ovsf_seq_ctrl #(
    parameter int W  = 8,
    parameter int LW = 4,
    parameter int MIN_LOG = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          par_mode,
    input  logic          sym_start,
    input  logic [LW-1:0] n_in,
    input  logic [W-1:0]  rev_in,
    input  logic          ok_in,
    output logic [W-1:0]  cnt_q,
    output logic [W-1:0]  rev_q,
    output logic          vld_q,
    output logic          err_q
);
    typedef struct packed {
        logic [W-1:0]  cnt;
        logic [W-1:0]  rev;
        logic [LW-1:0] n;
        logic          active;
        logic          vld;
        logic          err;
    } seq_t;

    seq_t s_d, s_q;
    logic [W:0] last_w;
    logic       at_last;

    assign last_w  = ((W+1)'(1) << s_q.n) - (W+1)'(1);
    assign at_last = ({1'b0, s_q.cnt} == last_w);

    always_comb begin
        s_d = s_q;
        if (!en) begin
            s_d.vld = 1'b0;
        end else if (par_mode) begin
            s_d.active = 1'b0;
            s_d.vld    = 1'b0;
        end else if (sym_start) begin
            s_d.cnt    = '0;
            s_d.rev    = ok_in ? rev_in : '0;
            s_d.n      = ok_in ? n_in : LW'(MIN_LOG);
            s_d.err    = !ok_in;
            s_d.active = 1'b1;
            s_d.vld    = 1'b1;
        end else if (s_q.active) begin
            s_d.cnt = at_last ? '0 : s_q.cnt + W'(1);
            s_d.vld = 1'b1;
        end else begin
            s_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q   <= '0;
            s_q.n <= LW'(MIN_LOG);
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_q = s_q.cnt;
    assign rev_q = s_q.rev;
    assign vld_q = s_q.vld;
    assign err_q = s_q.err;

    // R3: the counter returns to chip 0 after the last chip of a symbol
    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !par_mode && !sym_start && s_q.active && at_last) |=> (s_q.cnt == '0));

    // R2: the counter steps by one inside a symbol
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !par_mode && !sym_start && s_q.active && !at_last)
        |=> (s_q.cnt == $past(s_q.cnt) + W'(1)));

    // R5: a disabled cycle holds the position and drops valid
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(s_q.cnt) && !s_q.vld));
endmodule

// File: rtl/ovsf_code_gen.sv
module ovsf_code_gen
    import ovsf_pkg::*;
#(
    parameter int MAX_LOG_SF = OVSF_MAX_LOG,
    parameter int MIN_LOG_SF = OVSF_MIN_LOG,
    parameter int WORD_W     = OVSF_WORD_W,
    localparam int LOG_W     = $clog2(MAX_LOG_SF + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic                  sym_start,
    input  logic                  par_mode,
    input  logic [LOG_W-1:0]      sf_log2,
    input  logic [MAX_LOG_SF-1:0] code_idx,
    output logic                  chip_out,
    output logic                  chip_vld,
    output logic [WORD_W-1:0]     word_out,
    output logic                  word_vld,
    output logic                  sym_bound,
    output logic                  code_err
);
    localparam int WORD_LOG = $clog2(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              vld;
        logic              err;
    } wrd_t;

    ovsf_mode_e mode;
    logic [MAX_LOG_SF-1:0] rev_in, cnt_q, rev_q;
    logic [WORD_W-1:0]     lanes;
    logic ok_in, word_ok, s_vld, s_err, s_chip;
    wrd_t w_d, w_q;

    assign mode    = ovsf_mode_e'(par_mode);
    assign ok_in   = (sf_log2 >= LOG_W'(MIN_LOG_SF)) && (sf_log2 <= LOG_W'(MAX_LOG_SF))
                     && ((code_idx >> sf_log2) == '0);
    assign word_ok = ok_in && (sf_log2 <= LOG_W'(WORD_LOG));

    ovsf_bitrev #(.W(MAX_LOG_SF), .LW(LOG_W)) u_rev (
        .idx (code_idx),
        .n   (sf_log2),
        .rev (rev_in)
    );

    ovsf_seq_ctrl #(.W(MAX_LOG_SF), .LW(LOG_W), .MIN_LOG(MIN_LOG_SF)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .par_mode  (mode == MODE_WORD),
        .sym_start (sym_start),
        .n_in      (sf_log2),
        .rev_in    (rev_in),
        .ok_in     (ok_in),
        .cnt_q     (cnt_q),
        .rev_q     (rev_q),
        .vld_q     (s_vld),
        .err_q     (s_err)
    );

    ovsf_chip_lane #(.W(MAX_LOG_SF)) u_ser_lane (
        .cnt  (cnt_q),
        .rev  (rev_q),
        .chip (s_chip)
    );

    for (genvar j = 0; j < WORD_W; j++) begin : g_lane
        ovsf_chip_lane #(.W(MAX_LOG_SF)) u_lane (
            .cnt  (MAX_LOG_SF'(j)),
            .rev  (rev_in),
            .chip (lanes[j])
        );
    end

    always_comb begin
        w_d     = w_q;
        w_d.vld = 1'b0;
        w_d.err = 1'b0;
        if (en && mode == MODE_WORD) begin
            w_d.vld  = 1'b1;
            w_d.err  = !word_ok;
            w_d.word = word_ok ? lanes : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign chip_out  = s_vld & ~s_err & s_chip;
    assign chip_vld  = s_vld;
    assign word_out  = w_q.word;
    assign word_vld  = w_q.vld;
    assign sym_bound = (s_vld && cnt_q == '0) || w_q.vld;
    assign code_err  = (s_vld & s_err) | (w_q.vld & w_q.err);

    // R9: the two modes never present output together
    p_mode_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(chip_vld && word_vld));

    // R6: a word-mode request yields a word in the next cycle
    p_word_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && par_mode) |=> (word_vld && sym_bound));

    // R7: a flagged output carries only +1 chips
    p_err_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        code_err |-> (!chip_out && (word_vld ? word_out == '0 : 1'b1)));

    // R4: a strobe in serial mode starts a symbol one cycle later
    p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !par_mode && sym_start) |=> (chip_vld && sym_bound));
endmodule

// File: tb/ovsf_code_gen_tb.sv
module ovsf_code_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n, en, sym_start, par_mode;
    logic [3:0]  sf_log2;
    logic [7:0]  code_idx;
    logic        chip_out, chip_vld, word_vld, sym_bound, code_err;
    logic [31:0] word_out;
    int checks = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ovsf_code_gen u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .sym_start(sym_start), .par_mode(par_mode),
        .sf_log2(sf_log2), .code_idx(code_idx), .chip_out(chip_out), .chip_vld(chip_vld),
        .word_out(word_out), .word_vld(word_vld), .sym_bound(sym_bound), .code_err(code_err)
    );

    // Recursive OVSF construction: 1 marks a -1 chip.
    function automatic bit ref_chip(int n, int k, int c);
        bit v = 0;
        for (int lvl = n; lvl >= 1; lvl--) begin
            int half = 1 << (lvl - 1);
            int kk   = k >> (n - lvl);
            if ((kk & 1) && ((c % (1 << lvl)) >= half)) v = !v;
        end
        return v;
    endfunction

    task automatic chk(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_chip(string tag, bit exp_chip, bit exp_bnd);
        chk(chip_vld === 1'b1, {tag, " vld"}, chip_vld, 1);
        chk(chip_out === exp_chip, {tag, " chip"}, chip_out, exp_chip);
        chk(sym_bound === exp_bnd, {tag, " bound"}, sym_bound, exp_bnd);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; en = 0; sym_start = 0; par_mode = 0; sf_log2 = 2; code_idx = 0;
        repeat (3) tick;
        chk({chip_vld, word_vld, sym_bound, code_err} === 4'b0, "R1 reset outputs",
            {chip_vld, word_vld, sym_bound, code_err}, 0);
        rst_n = 1;
        tick;

        // R2 / R3: every code, each new strobe lands on the wrap edge
        for (int n = 2; n <= 8; n++) begin
            for (int k = 0; k < (1 << n); k++) begin
                en = 1; sym_start = 1; sf_log2 = 4'(n); code_idx = 8'(k);
                tick;
                sym_start = 0;
                chk_chip("R2 chip0", ref_chip(n, k, 0), 1'b1);
                for (int c = 1; c < (1 << n); c++) begin
                    tick;
                    chk_chip("R2 chip", ref_chip(n, k, c), 1'b0);
                end
            end
        end

        // R3: free repetition over three symbols
        sym_start = 1; sf_log2 = 3; code_idx = 5;
        tick;
        sym_start = 0;
        chk_chip("R3 rep", ref_chip(3, 5, 0), 1'b1);
        for (int c = 1; c < 24; c++) begin
            tick;
            chk_chip("R3 rep", ref_chip(3, 5, c % 8), (c % 8) == 0);
        end

        // R5: stall mid symbol, strobe while disabled is ignored
        sym_start = 1; sf_log2 = 4; code_idx = 5;
        tick;
        sym_start = 0;
        for (int c = 1; c <= 4; c++) tick;
        en = 0; sym_start = 1; sf_log2 = 2; code_idx = 1;
        for (int c = 0; c < 3; c++) begin
            tick;
            chk(chip_vld === 1'b0, "R5 stall vld", chip_vld, 0);
        end
        en = 1; sym_start = 0;
        tick;
        chk_chip("R5 resume", ref_chip(4, 5, 5), 1'b0);
        tick;
        chk_chip("R5 resume", ref_chip(4, 5, 6), 1'b0);

        // R4: restart in mid symbol with new parameters
        sym_start = 1; sf_log2 = 5; code_idx = 3;
        tick;
        sym_start = 0;
        for (int c = 1; c < 7; c++) tick;
        sym_start = 1; sf_log2 = 3; code_idx = 6;
        tick;
        sym_start = 0;
        chk_chip("R4 restart", ref_chip(3, 6, 0), 1'b1);
        for (int c = 1; c < 8; c++) begin
            tick;
            chk_chip("R4 restart", ref_chip(3, 6, c), 1'b0);
        end

        // R7: index out of range and bad spreading factor in serial mode
        sym_start = 1; sf_log2 = 3; code_idx = 8;
        tick;
        sym_start = 0;
        for (int c = 0; c < 8; c++) begin
            chk(code_err === 1'b1, "R7 idx err", code_err, 1);
            chk(chip_vld === 1'b1 && chip_out === 1'b0, "R7 idx chip", chip_out, 0);
            tick;
        end
        sym_start = 1; sf_log2 = 9; code_idx = 1;
        tick;
        sym_start = 0;
        chk(code_err === 1'b1 && chip_out === 1'b0, "R7 sf err", {code_err, chip_out}, 2);
        sym_start = 1; sf_log2 = 1; code_idx = 0;
        tick;
        sym_start = 0;
        chk(code_err === 1'b1, "R7 sf low err", code_err, 1);

        // R6: every word-mode code up to SF 32
        par_mode = 1;
        for (int n = 2; n <= 5; n++) begin
            for (int k = 0; k < (1 << n); k++) begin
                logic [31:0] exp_w;
                sf_log2 = 4'(n); code_idx = 8'(k);
                for (int j = 0; j < 32; j++) exp_w[j] = ref_chip(n, k, j % (1 << n));
                tick;
                chk(word_vld === 1'b1 && sym_bound === 1'b1 && code_err === 1'b0,
                    "R6 word flags", {word_vld, sym_bound, code_err}, 6);
                chk(word_out === exp_w, "R6 word", word_out, exp_w);
            end
        end

        // R8 / R7: word mode errors
        sf_log2 = 6; code_idx = 1;
        tick;
        chk(code_err === 1'b1 && word_out === 32'h0, "R8 sf64 word", word_out, 0);
        sf_log2 = 2; code_idx = 4;
        tick;
        chk(code_err === 1'b1 && word_out === 32'h0, "R7 word idx", word_out, 0);

        // R9: word mode stops the serial sequence
        par_mode = 0; sym_start = 0; sf_log2 = 3; code_idx = 1;
        tick;
        chk(chip_vld === 1'b0 && word_vld === 1'b0, "R9 serial idle", {chip_vld, word_vld}, 0);
        tick;
        chk(chip_vld === 1'b0, "R9 serial idle", chip_vld, 0);
        sym_start = 1;
        tick;
        sym_start = 0;
        chk(word_vld === 1'b0, "R9 excl", word_vld, 0);
        chk_chip("R9 new start", ref_chip(3, 1, 0), 1'b1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule